// File: doc/BRIEF.md
# 100BASE-TX Transmit Code-Group Framer

This block sits between the transmit side of an MII and the scrambler of a 100 Mb/s twisted-pair physical layer. It runs on the 25 MHz transmit clock. On every edge it takes one nibble together with the enable and error strobes, and each cycle it produces one 5-bit code group. Between frames it sends the idle code continuously. When the enable rises, the first two preamble nibbles are dropped and the start-of-stream pair J, K goes out in their place. Every later nibble is translated through the 4B/5B table. When the enable drops, the end-of-stream pair T, R closes the frame.

The output is registered, so a code group appears one clock after the nibble that produced it is sampled. A request to start that arrives while the closing pair is still being sent waits until R has been sent. The nibble that comes with such a request is thrown away.

Top module: `txsym_framer`

## Requirements
- R1: While `rst` is high on a clock edge, `code_out` is 11111 after that edge.
- R2: In the idle state, each edge with `tx_en` low gives `code_out` = 11111 (I). `tx_er` and `tx_nib` have no effect there.
- R3: In the idle state, an edge with `tx_en` high gives J = 11000. If the next edge still has `tx_en` high, it gives K = 10001. The nibbles sampled on these two edges are not encoded.
- R4: After K, each edge with `tx_en` high and `tx_er` low gives the code for `tx_nib`: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: In the data phase, an edge with both `tx_en` and `tx_er` high gives the error code H = 00100 in place of the data code.
- R6: The first edge with `tx_en` low after the data phase gives T = 01101. The next edge gives R = 00111. After that the block is idle again.
- R7: On the edge that gives R, `tx_en` is ignored and the nibble is discarded. If `tx_en` is high on the following edge, that edge gives J.
- R8: If `tx_en` is low on the edge right after J, that edge gives T instead of K, followed by R.
- R9: Each code group appears on `code_out` exactly one clock after the edge that sampled its inputs, and it stays there for the whole clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_er | input | 1 | Transmit error strobe from the MAC |
| tx_nib | input | 4 | Transmit nibble |
| code_out | output | 5 | Registered 5-bit code group |

## Verification
The assertions run on every cycle and check the ordering rules seen at the port. Idle follows idle while the enable is low. J follows idle when the enable is high, and J is followed by K or T. T always precedes R, and R is followed by I or J. An error during data gives H, a dropped enable during data gives T, and any other data cycle gives some legal data code. The assertions cannot show which code a nibble gets, that the two nibbles replaced by J and K really vanish, or that a start request made during R loses its nibble. The bench reference model covers these through scenarios that step through all sixteen nibbles, one-cycle and two-cycle frames, errors both inside and outside a frame, and back-to-back frames.

// File: rtl/txsym_pkg.sv
package txsym_pkg;

  localparam int NIB_W = 4;
  localparam int SYM_W = 5;

  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
  localparam logic [SYM_W-1:0] CG_H    = 5'b00100;

  // sequencer position: what the next sampled edge will decide
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SSD2 = 2'd1,
    SQ_DATA = 2'd2,
    SQ_ESD2 = 2'd3
  } seq_t;

  // which code group the output register loads
  typedef enum logic [2:0] {
    PICK_IDLE = 3'd0,
    PICK_J    = 3'd1,
    PICK_K    = 3'd2,
    PICK_DATA = 3'd3,
    PICK_ERR  = 3'd4,
    PICK_T    = 3'd5,
    PICK_R    = 3'd6
  } pick_t;

endpackage

// File: rtl/txsym_nib_enc.sv
module txsym_nib_enc
  import txsym_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output logic [SYM_W-1:0] code
);

  always_comb begin
    unique case (nib)
      4'h0: code = 5'b11110;
      4'h1: code = 5'b01001;
      4'h2: code = 5'b10100;
      4'h3: code = 5'b10101;
      4'h4: code = 5'b01010;
      4'h5: code = 5'b01011;
      4'h6: code = 5'b01110;
      4'h7: code = 5'b01111;
      4'h8: code = 5'b10010;
      4'h9: code = 5'b10011;
      4'hA: code = 5'b10110;
      4'hB: code = 5'b10111;
      4'hC: code = 5'b11010;
      4'hD: code = 5'b11011;
      4'hE: code = 5'b11100;
      default: code = 5'b11101;
    endcase
  end

endmodule

// File: rtl/txsym_seq.sv
module txsym_seq
  import txsym_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  err,
  output pick_t pick
);

  seq_t cur, nxt;

  always_comb begin
    nxt  = cur;
    pick = PICK_IDLE;
    unique case (cur)
      SQ_IDLE: begin
        if (en) begin
          pick = PICK_J;   // first preamble nibble replaced
          nxt  = SQ_SSD2;
        end
      end
      SQ_SSD2: begin
        if (en) begin
          pick = PICK_K;   // second preamble nibble replaced
          nxt  = SQ_DATA;
        end else begin
          pick = PICK_T;   // frame ended right after J
          nxt  = SQ_ESD2;
        end
      end
      SQ_DATA: begin
        if (en) begin
          pick = err ? PICK_ERR : PICK_DATA;
        end else begin
          pick = PICK_T;
          nxt  = SQ_ESD2;
        end
      end
      default: begin
        pick = PICK_R;     // enable ignored while R goes out
        nxt  = SQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= SQ_IDLE;
    else     cur <= nxt;
  end

endmodule

// File: rtl/txsym_outreg.sv
module txsym_outreg
  import txsym_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  pick_t            pick,
  input  logic [SYM_W-1:0] data_code,
  output logic [SYM_W-1:0] code_q
);

  logic [SYM_W-1:0] code_d;

  always_comb begin
    unique case (pick)
      PICK_J:    code_d = CG_J;
      PICK_K:    code_d = CG_K;
      PICK_DATA: code_d = data_code;
      PICK_ERR:  code_d = CG_H;
      PICK_T:    code_d = CG_T;
      PICK_R:    code_d = CG_R;
      default:   code_d = CG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= CG_IDLE;
    else     code_q <= code_d;
  end

endmodule

// File: rtl/txsym_framer.sv
module txsym_framer
  import txsym_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] tx_nib,
  output logic [SYM_W-1:0] code_out
);

  logic [SYM_W-1:0] enc_code;
  pick_t            pick;

  txsym_nib_enc u_enc (
    .nib  (tx_nib),
    .code (enc_code)
  );

  txsym_seq u_seq (
    .clk  (clk),
    .rst  (rst),
    .en   (tx_en),
    .err  (tx_er),
    .pick (pick)
  );

  txsym_outreg u_out (
    .clk       (clk),
    .rst       (rst),
    .pick      (pick),
    .data_code (enc_code),
    .code_q    (code_out)
  );

endmodule

// File: rtl/txsym_framer_chk.sv
module txsym_framer_chk
  import txsym_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             tx_en,
  input logic             tx_er,
  input logic [SYM_W-1:0] code_out
);

  logic in_data;
  logic is_data_code;

  assign in_data = (code_out != CG_IDLE) && (code_out != CG_J) &&
                   (code_out != CG_T) && (code_out != CG_R);
  assign is_data_code = in_data && (code_out != CG_K) && (code_out != CG_H);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> code_out == CG_IDLE); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (code_out == CG_IDLE && !tx_en) |=> code_out == CG_IDLE); // R2

  AST_START_J: assert property (@(posedge clk) disable iff (rst)
    (code_out == CG_IDLE && tx_en) |=> code_out == CG_J); // R3

  AST_J_THEN_K: assert property (@(posedge clk) disable iff (rst)
    (code_out == CG_J && tx_en) |=> code_out == CG_K); // R3

  AST_DATA_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (in_data && tx_en && !tx_er) |=> is_data_code); // R4

  AST_ERR_H: assert property (@(posedge clk) disable iff (rst)
    (in_data && tx_en && tx_er) |=> code_out == CG_H); // R5

  AST_END_T: assert property (@(posedge clk) disable iff (rst)
    (in_data && !tx_en) |=> code_out == CG_T); // R6

  AST_T_THEN_R: assert property (@(posedge clk) disable iff (rst)
    (code_out == CG_T) |=> code_out == CG_R); // R6

  AST_AFTER_R: assert property (@(posedge clk) disable iff (rst)
    (code_out == CG_R) |=> (code_out == CG_IDLE || code_out == CG_J)); // R7

  AST_SHORT_T: assert property (@(posedge clk) disable iff (rst)
    (code_out == CG_J && !tx_en) |=> code_out == CG_T); // R8

endmodule

bind txsym_framer txsym_framer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_en    (tx_en),
  .tx_er    (tx_er),
  .code_out (code_out)
);

// File: tb/tb_txsym_framer.sv
module tb_txsym_framer;

  localparam int CLK_PERIOD = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] tx_nib = 4'h0;
  logic [4:0] code_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  txsym_framer dut (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .tx_er    (tx_er),
    .tx_nib   (tx_nib),
    .code_out (code_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0] tbl [16];
  initial begin
    tbl[0]=5'b11110; tbl[1]=5'b01001; tbl[2]=5'b10100; tbl[3]=5'b10101;
    tbl[4]=5'b01010; tbl[5]=5'b01011; tbl[6]=5'b01110; tbl[7]=5'b01111;
    tbl[8]=5'b10010; tbl[9]=5'b10011; tbl[10]=5'b10110; tbl[11]=5'b10111;
    tbl[12]=5'b11010; tbl[13]=5'b11011; tbl[14]=5'b11100; tbl[15]=5'b11101;
  end

  // Reference model: counts frame position and tail slots as integers
  int         nib_count = 0;   // nibbles accepted in the current frame
  int         tail_left = 0;   // closing symbols still owed
  logic [4:0] exp_code = 5'b11111;
  string      exp_tag = "R1";
  bit         model_live = 1'b0;

  always @(posedge clk) begin
    model_live = 1'b1;
    if (rst) begin
      nib_count = 0; tail_left = 0;
      exp_code = 5'b11111; exp_tag = "R1";
    end else if (tail_left == 1) begin
      exp_code = 5'b00111; exp_tag = "R7";
      tail_left = 0; nib_count = 0;
    end else if (nib_count == 0) begin
      if (tx_en) begin exp_code = 5'b11000; exp_tag = "R3"; nib_count = 1; end
      else begin exp_code = 5'b11111; exp_tag = "R2"; end
    end else if (!tx_en) begin
      exp_code = 5'b01101;
      exp_tag = (nib_count == 1) ? "R8" : "R6";
      tail_left = 1;
    end else begin
      nib_count++;
      if (nib_count == 2) begin exp_code = 5'b10001; exp_tag = "R3"; end
      else if (tx_er) begin exp_code = 5'b00100; exp_tag = "R5"; end
      else begin exp_code = tbl[tx_nib]; exp_tag = "R4"; end
    end
  end

  // compare at every falling edge (R9: value held through the cycle)
  always @(negedge clk) begin
    if (model_live && !done) begin
      checks++;
      if (code_out !== exp_code) begin
        fails++;
        $display("FAIL %s R9 t=%0t actual=%b expected=%b", exp_tag, $time, code_out, exp_code);
      end
    end
  end

  task automatic step(input bit en, input bit er, input logic [3:0] nib);
    @(negedge clk);
    #1;
    tx_en = en; tx_er = er; tx_nib = nib;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, (i % 2) == 1, 4'(i)); // R2: er/nib ignored
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    idle(4);
    // full frame: preamble then every nibble value (R3, R4, R6)
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 4'h5);
    step(1'b1, 1'b0, 4'hD);
    for (int v = 0; v < 16; v++) step(1'b1, 1'b0, 4'(v));
    idle(3);
    // error inside data (R5)
    step(1'b1, 1'b0, 4'h5); step(1'b1, 1'b0, 4'h5);
    step(1'b1, 1'b0, 4'hA); step(1'b1, 1'b1, 4'hA); step(1'b1, 1'b0, 4'h3);
    idle(2);
    // one-cycle frame: J then T then R (R8)
    step(1'b1, 1'b0, 4'h5);
    idle(4);
    // two-cycle frame: J K then T R
    step(1'b1, 1'b0, 4'h5); step(1'b1, 1'b1, 4'h5);
    idle(3);
    // back-to-back: enable returns during R slot (R7)
    step(1'b1, 1'b0, 4'h5); step(1'b1, 1'b0, 4'h5); step(1'b1, 1'b0, 4'h7);
    step(1'b0, 1'b0, 4'h0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 4'h9);
    idle(3);
    // reset in the middle of a frame (R1)
    step(1'b1, 1'b0, 4'h5); step(1'b1, 1'b0, 4'h5); step(1'b1, 1'b0, 4'h1);
    @(negedge clk); #1 rst = 1'b1;
    @(negedge clk); #1 rst = 1'b0; tx_en = 1'b0;
    idle(4);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule